// File: doc/BRIEF.md
# Multi-Framing Serial Peripheral Master

This block drives one serial peripheral bus from the core clock. It has a selectable group of chip-enable outputs. A transfer starts with a one-cycle `start` strobe. On that strobe the block captures the byte to send, the framing, the clock polarity and phase, the chip-enable polarity, the target index and the divider value. These captured settings hold until the transfer ends. When the transfer completes, the received byte appears on `rx_data` and `done` pulses for one cycle.

There are three framings.

- **Full-duplex:** four wires, eight bits each way.
- **Half-duplex:** a single data wire. The outgoing pin is turned around through an output-enable, so each transfer either sends or receives.
- **Nine-bit:** intended for display controllers. A command/data flag goes out ahead of the byte.

The serial clock comes from the core clock through an even divider. Around each transfer, the chip enable is held active for a fixed number of core cycles before the first clock edge and after the last one.

Top module: `spim_top`

## Requirements
- R1: The SCLK half-period is floor(cdiv/2) core cycles. A cdiv of 0 or 1 gives a half-period of 2^(DIV_W-1), which is a full divisor of 65536 at the default width. A transfer of B bits takes CE_SETUP + 2·B·H + CE_HOLD core cycles from the start edge to the `done` cycle.
- R2: The selected chip enable becomes active in the cycle after the start edge. The first SCLK transition comes exactly CE_SETUP + H cycles after the start edge, so the enable always leads it by at least CE_SETUP cycles.
- R3: The chip enable stays active for CE_HOLD cycles after the last SCLK transition. It returns to idle in the same cycle that `done` is high.
- R4: With frame_sel = 0 (code 3 acts the same), eight bits go out on `sdo` most significant first. Eight bits are sampled from `sdi`, most significant first, into `rx_data`.
- R5: `cpol` sets the SCLK level between transfers. With `cpha` = 0, data is sampled on the odd (leading) edges and changes on the even edges. With `cpha` = 1, data changes on the leading edges and is sampled on the trailing edges.
- R6: With frame_sel = 1, the line is shared. If `tri_rx` = 0, `sdo` drives eight bits with `sdo_oe` high, and `rx_data` is left unchanged. If `tri_rx` = 1, `sdo_oe` is low for the whole transfer, eight bits are sampled from `sdio_in`, and `sdi` is ignored. Outside a transfer, `sdo_oe` is low after a half-duplex transfer and high after any other.
- R7: With frame_sel = 2, nine bits go out: `dc_flag` first (1 for data, 0 for command), then the byte most significant first. `rx_data` takes the last eight bits sampled from `sdi`.
- R8: Only output `ce_idx` of `ce_out` is active during a transfer. The active level is high when `ce_high` = 1 and low otherwise. Between transfers, every output sits at the inactive level of the last captured polarity.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running transfer keeps its data, divider, target and timing.
- R10: `busy` is high from the cycle after the start edge until `done`. `done` is a single-cycle pulse, and `busy` is already low in that cycle.
- R11: After reset, `busy`, `done`, `sclk` and `rx_data` are zero, every `ce_out` bit is high, and `sdo_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer when idle |
| tx_data | input | DATA_W | Byte to send |
| dc_flag | input | 1 | Leading flag in nine-bit framing, 1 = data |
| frame_sel | input | 2 | 0 full-duplex, 1 shared line, 2 nine-bit |
| tri_rx | input | 1 | Shared-line direction, 1 = receive |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | Sampling edge select |
| ce_high | input | 1 | Chip-enable active level |
| ce_idx | input | SEL_W | Target chip-enable index |
| cdiv | input | DIV_W | Clock divider value |
| sdi | input | 1 | Serial input, four-wire and nine-bit framings |
| sdio_in | input | 1 | Pad input of the shared data line |
| rx_data | output | DATA_W | Last received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial output / shared line output value |
| sdo_oe | output | 1 | Output enable of the data line |
| ce_out | output | NUM_CE | Chip-enable outputs |

## Verification
The start edge is taken as cycle zero, and every later result is placed by counting core cycles from it. The first SCLK transition is due CE_SETUP + H cycles later. `done` and the chip-enable release are due CE_SETUP + 2·B·H + CE_HOLD cycles later. The received byte is valid in that same `done` cycle. The bench samples on the falling clock edge, records the cycle of each event, and compares it with the count worked out from cdiv and the framing. A peripheral model reacts to every SCLK transition and does two jobs: it captures the outgoing bits and supplies the incoming ones. This lets the bench check data values and edge ordering independently of the cycle counts.

// File: rtl/spim_pkg.sv
package spim_pkg;

   typedef enum logic [1:0] {
      FR_QUAD = 2'd0,
      FR_TRI  = 2'd1,
      FR_NINE = 2'd2
   } frame_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_SHIFT,
      ST_HOLD
   } phase_e;

   typedef struct packed {
      frame_e frame;
      logic   tri_rx;
      logic   cpol;
      logic   cpha;
      logic   ce_hi;
   } xfer_cfg_t;

   function automatic frame_e decode_frame(input logic [1:0] code);
      case (code)
         2'd1:    return FR_TRI;
         2'd2:    return FR_NINE;
         default: return FR_QUAD;
      endcase
   endfunction

endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == half - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + DIV_W'(1);
   end

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
   parameter int TX_W = 9,
   parameter int RX_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [TX_W-1:0] load_word,
   input  logic            shift_out,
   input  logic            sample_in,
   input  logic            in_bit,
   output logic            tx_msb,
   output logic [RX_W-1:0] rx_word
);

   logic [TX_W-1:0] tx_q;
   logic [RX_W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_q <= '0;
      else if (load)
         tx_q <= load_word;
      else if (shift_out)
         tx_q <= {tx_q[TX_W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_q <= '0;
      else if (sample_in)
         rx_q <= {rx_q[RX_W-2:0], in_bit};
   end

   assign tx_msb  = tx_q[TX_W-1];
   assign rx_word = rx_q;

endmodule

// File: rtl/spim_cedrv.sv
module spim_cedrv #(
   parameter int NUM_CE = 2,
   parameter int SEL_W  = 1
) (
   input  logic              active,
   input  logic [SEL_W-1:0]  sel,
   input  logic              act_high,
   output logic [NUM_CE-1:0] ce_out
);

   for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
      assign ce_out[i] = (active && (sel == SEL_W'(i))) ? act_high : ~act_high;
   end

endmodule

// File: rtl/spim_top.sv
module spim_top
   import spim_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NUM_CE   = 2,
   parameter int DIV_W    = 16,
   parameter int CE_SETUP = 3,
   parameter int CE_HOLD  = 1,
   localparam int SEL_W   = (NUM_CE > 1) ? $clog2(NUM_CE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              dc_flag,
   input  logic [1:0]        frame_sel,
   input  logic              tri_rx,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              ce_high,
   input  logic [SEL_W-1:0]  ce_idx,
   input  logic [DIV_W-1:0]  cdiv,
   input  logic              sdi,
   input  logic              sdio_in,
   output logic [DATA_W-1:0] rx_data,
   output logic              busy,
   output logic              done,
   output logic              sclk,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [NUM_CE-1:0] ce_out
);

   localparam int FRAME_W = DATA_W + 1;
   localparam int EDGE_W  = $clog2(2 * FRAME_W + 1);
   localparam int GAP_MAX = (CE_SETUP > CE_HOLD) ? CE_SETUP : CE_HOLD;
   localparam int GAP_W   = $clog2(GAP_MAX + 1);
   localparam logic [EDGE_W-1:0] EDGES_WORD = EDGE_W'(2 * DATA_W);
   localparam logic [EDGE_W-1:0] EDGES_NINE = EDGE_W'(2 * FRAME_W);
   localparam logic [GAP_W-1:0]  SETUP_LAST = GAP_W'(CE_SETUP - 1);
   localparam logic [GAP_W-1:0]  HOLD_LAST  = GAP_W'(CE_HOLD - 1);

   if (DATA_W < 2) begin : g_bad_data
      $error("spim_top: DATA_W must be at least 2");
   end
   if (NUM_CE < 1) begin : g_bad_ce
      $error("spim_top: NUM_CE must be at least 1");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("spim_top: DIV_W must be at least 2");
   end
   if (CE_SETUP < 1 || CE_HOLD < 1) begin : g_bad_gap
      $error("spim_top: CE_SETUP and CE_HOLD must be at least 1");
   end

   phase_e            st;
   xfer_cfg_t         cfg, cfg_new;
   logic [SEL_W-1:0]  sel_q;
   logic [DIV_W-1:0]  half_q, half_new;
   logic [EDGE_W-1:0] edges, edge_nxt, last_edge;
   logic [GAP_W-1:0]  gap;
   logic              sclk_q, done_q;
   logic [DATA_W-1:0] rx_q, rx_shift;
   logic [FRAME_W-1:0] load_word;
   logic              tick, lead, sample_now, shift_now, rx_en, in_bit, accept;

   // settings captured at start
   always_comb begin
      cfg_new.frame  = decode_frame(frame_sel);
      cfg_new.tri_rx = tri_rx;
      cfg_new.cpol   = cpol;
      cfg_new.cpha   = cpha;
      cfg_new.ce_hi  = ce_high;
      if (cdiv[DIV_W-1:1] == '0)
         half_new = {1'b1, {(DIV_W-1){1'b0}}};
      else
         half_new = {1'b0, cdiv[DIV_W-1:1]};
      if (cfg_new.frame == FR_NINE)
         load_word = {dc_flag, tx_data};
      else
         load_word = {tx_data, 1'b0};
   end

   assign accept     = start && (st == ST_IDLE);
   assign edge_nxt   = edges + EDGE_W'(1);
   assign lead       = edge_nxt[0];
   assign last_edge  = (cfg.frame == FR_NINE) ? EDGES_NINE : EDGES_WORD;
   assign sample_now = tick && (lead ^ cfg.cpha) && rx_en;
   assign shift_now  = tick && !(lead ^ cfg.cpha) && !(cfg.cpha && (edge_nxt == EDGE_W'(1)));
   assign rx_en      = (cfg.frame != FR_TRI) || cfg.tri_rx;
   assign in_bit     = (cfg.frame == FR_TRI) ? sdio_in : sdi;

   spim_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st == ST_SHIFT),
      .half  (half_q),
      .tick  (tick)
   );

   spim_shift #(.TX_W(FRAME_W), .RX_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_word (load_word),
      .shift_out (shift_now),
      .sample_in (sample_now),
      .in_bit    (in_bit),
      .tx_msb    (sdo),
      .rx_word   (rx_shift)
   );

   spim_cedrv #(.NUM_CE(NUM_CE), .SEL_W(SEL_W)) u_ce (
      .active   (st != ST_IDLE),
      .sel      (sel_q),
      .act_high (cfg.ce_hi),
      .ce_out   (ce_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cfg    <= '0;
         sel_q  <= '0;
         half_q <= '0;
         edges  <= '0;
         gap    <= '0;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
         rx_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  cfg    <= cfg_new;
                  sel_q  <= ce_idx;
                  half_q <= half_new;
                  sclk_q <= cpol;
                  edges  <= '0;
                  gap    <= '0;
                  st     <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (gap == SETUP_LAST) begin
                  gap <= '0;
                  st  <= ST_SHIFT;
               end else begin
                  gap <= gap + GAP_W'(1);
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  sclk_q <= ~sclk_q;
                  edges  <= edge_nxt;
                  if (edge_nxt == last_edge)
                     st <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (gap == HOLD_LAST) begin
                  st     <= ST_IDLE;
                  done_q <= 1'b1;
                  if (rx_en)
                     rx_q <= rx_shift;
               end else begin
                  gap <= gap + GAP_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st != ST_IDLE);
   assign done    = done_q;
   assign sclk    = sclk_q;
   assign rx_data = rx_q;
   assign sdo_oe  = (cfg.frame != FR_TRI) || (busy && !cfg.tri_rx);

endmodule

// File: rtl/spim_checks.sv
module spim_checks #(
   parameter int NUM_CE   = 2,
   parameter int DIV_W    = 16,
   parameter int CE_SETUP = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              sclk,
   input logic              sdo_oe,
   input logic [NUM_CE-1:0] ce_out,
   input logic              cfg_cpol,
   input logic              cfg_ce_hi,
   input logic [1:0]        cfg_frame,
   input logic              cfg_tri_rx,
   input logic [DIV_W-1:0]  half_q
);

   localparam int RUN_W = $clog2(CE_SETUP + 2) + 1;

   logic [RUN_W-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_cnt <= '0;
      else if (!busy)
         run_cnt <= '0;
      else if (run_cnt != '1)
         run_cnt <= run_cnt + RUN_W'(1);
   end

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   a_r2_ce_setup: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && (sclk != $past(sclk))) |-> (run_cnt >= RUN_W'(CE_SETUP)));

   a_r3_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $stable(sclk));

   a_r5_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == cfg_cpol));

   a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ce_out ^ {NUM_CE{~cfg_ce_hi}}));

   a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ce_out == {NUM_CE{~cfg_ce_hi}}));

   a_r6_line_released: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (cfg_frame == 2'd1) && cfg_tri_rx) |-> !sdo_oe);

   a_r9_divider_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(half_q));

endmodule

bind spim_top spim_checks #(
   .NUM_CE   (NUM_CE),
   .DIV_W    (DIV_W),
   .CE_SETUP (CE_SETUP)
) u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .sclk       (sclk),
   .sdo_oe     (sdo_oe),
   .ce_out     (ce_out),
   .cfg_cpol   (cfg.cpol),
   .cfg_ce_hi  (cfg.ce_hi),
   .cfg_frame  (cfg.frame),
   .cfg_tri_rx (cfg.tri_rx),
   .half_q     (half_q)
);

// File: tb/spim_top_bench.sv
`timescale 1ns/1ps
module spim_top_bench;

   localparam int DW    = 8;
   localparam int NCE   = 2;
   localparam int DIVW  = 6;
   localparam int SETUP = 3;
   localparam int HOLD  = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic dc_flag = 1'b0;
   logic [1:0] frame_sel = 2'd0;
   logic tri_rx = 1'b0, cpol = 1'b0, cpha = 1'b0, ce_high = 1'b0;
   logic [0:0] ce_idx = 1'b0;
   logic [DIVW-1:0] cdiv = 6'd2;
   logic sdi, sdio_in;
   logic [DW-1:0] rx_data;
   logic busy, done, sclk, sdo, sdo_oe;
   logic [NCE-1:0] ce_out;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   spim_top #(.DATA_W(DW), .NUM_CE(NCE), .DIV_W(DIVW), .CE_SETUP(SETUP), .CE_HOLD(HOLD)) u_spim_top (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data), .dc_flag(dc_flag),
      .frame_sel(frame_sel), .tri_rx(tri_rx), .cpol(cpol), .cpha(cpha), .ce_high(ce_high),
      .ce_idx(ce_idx), .cdiv(cdiv), .sdi(sdi), .sdio_in(sdio_in), .rx_data(rx_data),
      .busy(busy), .done(done), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .ce_out(ce_out)
   );

   // peripheral model
   logic [8:0] s_pat = '0;
   logic [8:0] s_cap = '0;
   int   s_idx = 0;
   int   s_edges = 0;
   bit   s_cpha = 1'b0;
   bit   s_tri = 1'b0;
   bit   s_armed = 1'b0;
   logic s_drv = 1'b0;

   assign sdi     = s_tri ? ~s_drv : s_drv;
   assign sdio_in = s_tri ? s_drv : ~s_drv;

   always @(sclk) begin
      if (s_armed) begin
         bit lead;
         s_edges++;
         lead = (s_edges % 2) == 1;
         if (lead ^ s_cpha) begin
            s_cap = {s_cap[7:0], sdo};
         end else if (!s_cpha) begin
            s_idx--;
            if (s_idx >= 0) s_drv = s_pat[s_idx];
         end else begin
            if (s_idx >= 0) s_drv = s_pat[s_idx];
            s_idx--;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int half_of(input int div);
      int c;
      c = (div >> 1) & 31;
      return (c == 0) ? 32 : c;
   endfunction

   function automatic int ce_vec(input bit act, input int idx, input bit hi);
      int v;
      v = hi ? 0 : 3;
      if (act) v = hi ? (1 << idx) : (3 & ~(1 << idx));
      return v;
   endfunction

   task automatic run_xfer(input int fr, input bit trx, input bit cp, input bit ph, input bit ceh,
                           input int idx, input int div, input logic [7:0] data, input bit dc,
                           input logic [8:0] pat, input bit poke);
      int efr, nb, h, exp_first, exp_done, n, first_n, oe_bad, ce_prev;
      logic [DW-1:0] prev_rx;
      logic [8:0] exp_tx;
      bit exp_oe;
      efr = (fr == 3) ? 0 : fr;
      nb = (efr == 2) ? 9 : 8;
      h = half_of(div);
      exp_first = SETUP + h;
      exp_done = SETUP + 2 * nb * h + HOLD;
      exp_tx = (efr == 2) ? {dc, data} : {1'b0, data};
      exp_oe = (efr == 1) ? !trx : 1'b1;
      prev_rx = rx_data;
      s_pat = pat; s_idx = nb - 1; s_cpha = ph; s_edges = 0; s_cap = '0;
      s_tri = (efr == 1) && trx;
      if (!ph) s_drv = pat[nb-1];
      frame_sel = 2'(fr); tri_rx = trx; cpol = cp; cpha = ph; ce_high = ceh;
      ce_idx = 1'(idx); cdiv = 6'(div); tx_data = data; dc_flag = dc;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      s_armed = 1'b1;
      n = 0; first_n = -1; oe_bad = 0;
      chk("R8", "selected enable active", int'(ce_out), ce_vec(1'b1, idx, ceh));
      chk("R10", "busy after start", int'(busy), 1);
      begin
         logic prev_sclk;
         prev_sclk = sclk;
         ce_prev = int'(ce_out);
         while (!done && n < 5000) begin
            if (poke) begin
               start = (n == 5);
               if (n == 5) begin
                  tx_data = ~data; cdiv = 6'(div + 4); ce_idx = ~1'(idx); frame_sel = 2'd2;
               end
            end
            ce_prev = int'(ce_out);
            @(negedge clk);
            n++;
            if (sclk != prev_sclk && first_n < 0) first_n = n;
            prev_sclk = sclk;
            if (busy && sdo_oe != exp_oe) oe_bad++;
         end
      end
      start = 1'b0;
      chk("R1", "cycles to done", n, exp_done);
      chk("R2", "cycles to first sclk edge", first_n, exp_first);
      chk("R3", "enable held until last cycle", ce_prev, ce_vec(1'b1, idx, ceh));
      chk("R3", "enable released with done", int'(ce_out), ce_vec(1'b0, idx, ceh));
      chk("R10", "busy low at done", int'(busy), 0);
      chk("R5", "sclk idle level", int'(sclk), int'(cp));
      if (efr == 1) chk("R6", "oe mismatches while busy", oe_bad, 0);
      if (efr == 1 && !trx)
         chk("R6", "rx kept on transmit-only", int'(rx_data), int'(prev_rx));
      else if (efr == 2)
         chk("R7", "nine-bit rx low byte", int'(rx_data), int'(pat[7:0]));
      else if (efr == 1)
         chk("R6", "shared-line rx byte", int'(rx_data), int'(pat[7:0]));
      else
         chk("R4", "full-duplex rx byte", int'(rx_data), int'(pat[7:0]));
      if (!(efr == 1 && trx)) begin
         if (efr == 2) chk("R7", "nine-bit tx word", int'(s_cap), int'(exp_tx));
         else chk("R4", "tx byte msb first", int'(s_cap[7:0]), int'(exp_tx[7:0]));
      end
      if (poke) chk("R9", "start while busy ignored, idle after", int'(busy), 0);
      @(negedge clk);
      s_armed = 1'b0;
      chk("R10", "done single cycle", int'(done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd7351));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "busy", int'(busy), 0);
      chk("R11", "done", int'(done), 0);
      chk("R11", "sclk", int'(sclk), 0);
      chk("R11", "ce_out", int'(ce_out), 3);
      chk("R11", "rx_data", int'(rx_data), 0);
      chk("R11", "sdo_oe", int'(sdo_oe), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // directed corner cases
      run_xfer(0, 0, 0, 0, 0, 0, 2,  8'hA5, 0, 9'h03C, 0); // R4 fastest divider
      run_xfer(0, 0, 1, 1, 0, 1, 3,  8'h5A, 0, 9'h0C3, 0); // R5 odd rounds down
      run_xfer(0, 0, 0, 1, 1, 1, 0,  8'h81, 0, 9'h07E, 0); // R1 zero divisor
      run_xfer(0, 0, 1, 0, 0, 0, 1,  8'h3C, 0, 9'h0F0, 0); // R1 one rounds to zero
      run_xfer(2, 0, 0, 0, 0, 0, 4,  8'h96, 1, 9'h1AB, 0); // R7 data flag
      run_xfer(2, 0, 1, 1, 1, 1, 6,  8'h2A, 0, 9'h055, 0); // R7 command flag
      run_xfer(1, 0, 0, 0, 0, 1, 4,  8'hC9, 0, 9'h0FF, 0); // R6 transmit only
      run_xfer(1, 1, 0, 1, 0, 0, 4,  8'h00, 0, 9'h0B2, 0); // R6 receive only
      run_xfer(1, 1, 1, 0, 1, 1, 2,  8'hFF, 0, 9'h04D, 0); // R6 receive cpha 0
      run_xfer(3, 0, 0, 0, 1, 1, 4,  8'h77, 0, 9'h0E1, 0); // R4 code 3 acts as 0
      run_xfer(0, 0, 0, 0, 0, 0, 6,  8'h1F, 0, 9'h0A6, 1); // R9 start while busy

      // constrained random
      for (int i = 0; i < 40; i++) begin
         run_xfer(int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  int'($urandom % 2), int'($urandom % 12), 8'($urandom), 1'($urandom),
                  9'($urandom), 1'($urandom % 8 == 0));
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule